// File: doc/BRIEF.md
# Word-Mark Serial Decimal Field Adder

This block adds one decimal field held in character memory into another, one character at a time, through a single memory port. The caller gives the address of the low-order character of the addend field (A) and of the augend/result field (B). The engine reads an A character, then reads a B character, then writes the sum character back over the B position. It then steps both addresses down by one and repeats. The field length is never given. The operation ends after the B character whose word-mark bit is set.

Every character fetched is checked for odd parity. Its low four bits are recoded into a two-part biquinary form, and that form must hold exactly one hot bit in each part before it is used in arithmetic. A failed check stops the engine before the bad character is written. A decimal carry runs from character to character, and a carry left over at the end is reported as overflow. In chained use, a new start with the chain input set keeps the address registers where the last operation left them. This lets adjacent fields below the first pair be added back to back without supplying addresses.

Top module: `wm_field_adder`

## Requirements
- R1: After reset, busy_o, done_o, err_o, ovf_o and mem_we_o are all low.
- R2: A character is 8 bits. Bit 7 is the word mark. Bit 6 is a parity bit that makes the number of ones in bits 6..0 odd. Bits 5..4 are zone bits. Bits 3..0 hold a decimal digit. Every written character has odd parity over bits 6..0.
- R3: For each character position, the engine reads the A address, then reads the B address, then writes the B address, one cycle each. Both addresses then decrement by one. A field of N characters therefore takes 3N cycles after the start edge.
- R4: The operation ends after the write of the B character whose bit 7 is set. done_o pulses for one cycle in the cycle after that write, and busy_o is low during that pulse.
- R5: Each result digit is the decimal sum of the A digit, the B digit and the incoming carry. The written character keeps the word mark and zone bits of the B character.
- R6: A carry out of the final position sets ovf_o. ovf_o holds until the next accepted start, which clears it. Result digits are always 0..9.
- R7: The word-mark bit of A characters has no effect on length or result.
- R8: A character failing the parity check, on either operand, stops the operation. err_o is set, done_o pulses, and that B position is not written. Positions already written keep their results. err_o clears on the next accepted start.
- R9: A digit value of 10..15 on either operand fails the biquinary validity check and is handled exactly as in R8.
- R10: A start with chain_i high ignores a_addr_i and b_addr_i. It continues from the address registers the previous operation left, which point one below the last positions it processed.
- R11: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start an add operation (sampled when idle) |
| chain_i | input | 1 | With start_i: reuse the address registers instead of the address inputs |
| a_addr_i | input | AW | Address of the low-order A character |
| b_addr_i | input | AW | Address of the low-order B character |
| mem_addr_o | output | AW | Memory address for the current cycle |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Character to write |
| mem_rdata_i | input | 8 | Character read from mem_addr_o (combinational read) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| err_o | output | 1 | Last operation stopped on a parity or digit error |
| ovf_o | output | 1 | Last operation produced a final carry |

## Verification
The bench targets carries that ripple across all positions of a field (999+1). If the carry were dropped between characters, the upper digits would come out wrong. If the last carry were lost, ovf_o would stay low. It places a word mark on a low-order A character. An engine that honoured it would stop early and leave the upper B digits unchanged. It corrupts parity in the middle of B and feeds a non-decimal A digit. These checks catch an engine that writes the bad position, runs on past it, or fails to pulse done. It also checks that a start pulse during a running operation and the address inputs during a chained start are both ignored, since either would redirect the reads and writes to the wrong field.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int CHAR_W  = 8;
  localparam int WM_BIT  = 7;
  localparam int PAR_BIT = 6;
  localparam int DIG_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_WR_B
  } wm_state_e;

  function automatic logic odd_par(input logic [5:0] data);
    return ~^data;
  endfunction
endpackage

// File: rtl/wm_char_check.sv
module wm_char_check
  import wm_pkg::*;
(
  input  logic [CHAR_W-1:0] char_i,
  output logic [DIG_W-1:0]  digit_o,
  output logic              ok_o
);
  logic [1:0] bi;
  logic [4:0] qui;
  logic       code_ok;
  logic       par_ok;

  // recode into biquinary: bi selects 0 or 5, qui selects 0..4
  always_comb begin
    bi  = 2'b00;
    qui = 5'b00000;
    if (char_i[3:0] <= 4'd4) begin
      bi  = 2'b01;
      qui = 5'b00001 << char_i[3:0];
    end else if (char_i[3:0] <= 4'd9) begin
      bi  = 2'b10;
      qui = 5'b00001 << (char_i[3:0] - 4'd5);
    end
  end

  assign code_ok = ($countones(bi) == 1) && ($countones(qui) == 1);
  assign par_ok  = ^char_i[PAR_BIT:0];

  always_comb begin
    digit_o = bi[1] ? 4'd5 : 4'd0;
    for (int i = 0; i < 5; i++) begin
      if (qui[i]) digit_o = digit_o + 4'(i);
    end
  end

  assign ok_o = code_ok && par_ok;

  // decoded biquinary must round-trip to the stored digit (R9)
  always_comb begin
    if (code_ok) begin
      p_bq_roundtrip_r9: assert (digit_o == char_i[3:0]);
    end
  end
endmodule

// File: rtl/wm_dec_add.sv
module wm_dec_add
  import wm_pkg::*;
(
  input  logic [DIG_W-1:0] a_i,
  input  logic [DIG_W-1:0] b_i,
  input  logic             cin_i,
  output logic [DIG_W-1:0] sum_o,
  output logic             cout_o
);
  logic [DIG_W:0] raw;

  assign raw    = {1'b0, a_i} + {1'b0, b_i} + {4'd0, cin_i};
  assign cout_o = raw >= 5'd10;
  assign sum_o  = cout_o ? 4'(raw - 5'd10) : raw[DIG_W-1:0];
endmodule

// File: rtl/wm_field_adder.sv
module wm_field_adder
  import wm_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chain_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [AW-1:0]     b_addr_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic [CHAR_W-1:0] mem_wdata_o,
  input  logic [CHAR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              ovf_o
);
  localparam logic [AW-1:0] ADDR_STEP = AW'(1);

  wm_state_e         state_q;
  logic [AW-1:0]     a_addr_q, b_addr_q;
  logic [CHAR_W-1:0] a_q, b_q;
  logic              carry_q, err_q, ovf_q, done_q;

  logic [DIG_W-1:0]  rd_digit;
  logic              rd_ok;
  logic [DIG_W-1:0]  sum_digit;
  logic              sum_cout;

  wm_char_check u_chk (
    .char_i  (mem_rdata_i),
    .digit_o (rd_digit),
    .ok_o    (rd_ok)
  );

  wm_dec_add u_add (
    .a_i    (a_q[DIG_W-1:0]),
    .b_i    (b_q[DIG_W-1:0]),
    .cin_i  (carry_q),
    .sum_o  (sum_digit),
    .cout_o (sum_cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      a_addr_q <= '0;
      b_addr_q <= '0;
      a_q      <= '0;
      b_q      <= '0;
      carry_q  <= 1'b0;
      err_q    <= 1'b0;
      ovf_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (!chain_i) begin
              a_addr_q <= a_addr_i;
              b_addr_q <= b_addr_i;
            end
            carry_q <= 1'b0;
            err_q   <= 1'b0;
            ovf_q   <= 1'b0;
            state_q <= ST_RD_A;
          end
        end
        ST_RD_A: begin
          a_q <= {mem_rdata_i[CHAR_W-1:DIG_W], rd_digit};
          if (!rd_ok) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD_B;
          end
        end
        ST_RD_B: begin
          b_q <= {mem_rdata_i[CHAR_W-1:DIG_W], rd_digit};
          if (!rd_ok) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WR_B;
          end
        end
        ST_WR_B: begin
          carry_q  <= sum_cout;
          a_addr_q <= a_addr_q - ADDR_STEP;
          b_addr_q <= b_addr_q - ADDR_STEP;
          if (b_q[WM_BIT]) begin
            ovf_q   <= sum_cout;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD_A;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = (state_q == ST_RD_A) ? a_addr_q : b_addr_q;
  assign mem_we_o    = (state_q == ST_WR_B);
  assign mem_wdata_o = {b_q[WM_BIT], odd_par({b_q[5:4], sum_digit}), b_q[5:4], sum_digit};
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign ovf_o       = ovf_q;

  p_we_spaced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_wdata_par_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ^mem_wdata_o[PAR_BIT:0]);
  p_wdata_digit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o[3:0] <= 4'd9));
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_err_nowrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!$past(mem_we_o) && done_o));
endmodule

// File: tb/sim_wm_field_adder.sv
module sim_wm_field_adder;
  localparam int CLK_P = 10;
  localparam int AW    = 14;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] e;
    logic [2:0]  len;
    logic        ovf;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{16'h0005, 16'h0003, 16'h0008, 3'd1, 1'b0},
    '{16'h0027, 16'h0015, 16'h0042, 3'd2, 1'b0},
    '{16'h0999, 16'h0001, 16'h0000, 3'd3, 1'b1},
    '{16'h1234, 16'h8765, 16'h9999, 3'd4, 1'b0},
    '{16'h0009, 16'h0009, 16'h0008, 3'd1, 1'b1},
    '{16'h0050, 16'h0050, 16'h0000, 3'd2, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          chain = 1'b0;
  logic [AW-1:0] a_addr = '0;
  logic [AW-1:0] b_addr = '0;
  logic [AW-1:0] m_addr;
  logic          m_we;
  logic [7:0]    m_wdata;
  logic [7:0]    m_rdata;
  logic          busy, done, err, ovf;
  logic [7:0]    mem [256];
  int            checks = 0;
  int            errors = 0;

  always #(CLK_P/2) clk = ~clk;

  assign m_rdata = mem[m_addr[7:0]];
  always @(posedge clk) if (m_we) mem[m_addr[7:0]] <= m_wdata;

  wm_field_adder #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chain_i(chain),
    .a_addr_i(a_addr), .b_addr_i(b_addr),
    .mem_addr_o(m_addr), .mem_we_o(m_we), .mem_wdata_o(m_wdata),
    .mem_rdata_i(m_rdata), .busy_o(busy), .done_o(done),
    .err_o(err), .ovf_o(ovf)
  );

  function automatic logic [7:0] mkchar(logic wm, logic [1:0] zone, logic [3:0] d);
    return {wm, ~^{zone, d}, zone, d};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_field(int hi, logic [15:0] bcd, int len, logic [1:0] zone, bit wm_end);
    for (int i = 0; i < len; i++)
      mem[hi-i] = mkchar(wm_end && (i == len-1), zone, bcd[4*i +: 4]);
  endtask

  // starts at a negedge; returns edge count up to and including done
  task automatic run_op(int a, int b, bit ch, int pulse_at, output int cyc);
    cyc = 0;
    a_addr = AW'(a); b_addr = AW'(b); chain = ch; start = 1'b1;
    while (cyc < 200) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
      if (pulse_at != 0 && cyc == pulse_at) begin
        start = 1'b1; chain = 1'b0; a_addr = '0; b_addr = '0;
      end
      if (done) break;
    end
    start = 1'b0;
    if (cyc >= 200) chk("R4", "timeout", 1, 0);
  endtask

  function automatic logic [15:0] read_bcd(int hi, int len);
    logic [15:0] r = '0;
    for (int i = 0; i < len; i++) r[4*i +: 4] = mem[hi-i][3:0];
    return r;
  endfunction

  initial begin
    #(CLK_P*150000);
    chk("R4", "watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] keep;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "ovf", ovf, 0);
    chk("R1", "we", m_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: A at 20, B at 40
    for (int v = 0; v < NV; v++) begin
      int len;
      int pbad;
      logic [15:0] got;
      logic [15:0] msk;
      len = int'(VEC[v].len);
      put_field(20, VEC[v].a, len, 2'b11, 1'b1);
      put_field(40, VEC[v].b, len, 2'b10, 1'b1);
      run_op(20, 40, 1'b0, 0, cyc);
      chk("R3", "cycles", cyc, 3*len + 1);
      chk("R4", "busy at done", busy, 0);
      msk = 16'hFFFF >> (16 - 4*len);
      got = read_bcd(40, len);
      chk("R5", "sum", int'(got & msk), int'(VEC[v].e & msk));
      chk("R6", "ovf", ovf, VEC[v].ovf);
      chk("R8", "err", err, 0);
      pbad = 0;
      for (int i = 0; i < len; i++) begin
        if (~^mem[40-i][6:0]) pbad++;
        if (mem[40-i][7] != (i == len-1)) pbad++;
        if (mem[40-i][5:4] != 2'b10) pbad++;
      end
      chk("R2", "result char fields", pbad, 0);
      chk("R5", "A field intact", int'(read_bcd(20, len) & msk), int'(VEC[v].a & msk));
      @(negedge clk);
      chk("R4", "done one cycle", done, 0);
    end

    // R7: word mark on the low-order A character is ignored
    put_field(200, 16'h0015, 2, 2'b11, 1'b0);
    mem[200][7] = 1'b1;
    put_field(220, 16'h0027, 2, 2'b00, 1'b1);
    run_op(200, 220, 1'b0, 0, cyc);
    chk("R7", "sum", int'(read_bcd(220, 2)), 16'h0042);
    chk("R7", "cycles", cyc, 7);

    // R10/R11: two adjacent pairs, busy start pulse ignored, then chained
    mem[0] = 8'h55;
    put_field(60, 16'h0015, 2, 2'b00, 1'b1);
    put_field(58, 16'h0038, 2, 2'b00, 1'b1);
    put_field(90, 16'h0027, 2, 2'b00, 1'b1);
    put_field(88, 16'h0046, 2, 2'b00, 1'b1);
    run_op(60, 90, 1'b0, 2, cyc);
    chk("R11", "cycles", cyc, 7);
    chk("R11", "first sum", int'(read_bcd(90, 2)), 16'h0042);
    run_op(0, 0, 1'b1, 0, cyc);
    chk("R10", "chained sum", int'(read_bcd(88, 2)), 16'h0084);
    chk("R10", "addr 0 untouched", mem[0], 8'h55);
    chk("R10", "first field kept", int'(read_bcd(90, 2)), 16'h0042);

    // R8: parity error on middle B character
    put_field(120, 16'h0222, 3, 2'b11, 1'b1);
    put_field(140, 16'h0111, 3, 2'b00, 1'b1);
    mem[139] = mem[139] ^ 8'h40;
    keep = mem[139];
    run_op(120, 140, 1'b0, 0, cyc);
    chk("R8", "err", err, 1);
    chk("R8", "cycles", cyc, 6);
    chk("R8", "first written", mem[140][3:0], 3);
    chk("R8", "bad not written", mem[139], keep);
    chk("R8", "later untouched", mem[138][3:0], 1);

    // R9: non-decimal A digit
    mem[160] = mkchar(1'b1, 2'b11, 4'hC);
    mem[180] = mkchar(1'b1, 2'b00, 4'h4);
    keep = mem[180];
    run_op(160, 180, 1'b0, 0, cyc);
    chk("R9", "err", err, 1);
    chk("R9", "cycles", cyc, 2);
    chk("R9", "B unchanged", mem[180], keep);

    // R8: err cleared by next start
    put_field(20, 16'h0003, 1, 2'b00, 1'b1);
    put_field(40, 16'h0004, 1, 2'b00, 1'b1);
    run_op(20, 40, 1'b0, 0, cyc);
    chk("R8", "err cleared", err, 0);
    chk("R5", "sum after error", mem[40][3:0], 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule